// File: doc/BRIEF.md
# At-Speed Path Delay Error Monitor

This block decides whether a register-to-register path settles within half a clock period. While enabled it toggles a launch output once per rising clock edge, which drives an external path under test. The returning signal is captured twice per transition: once on the falling edge that follows the launch, and once on the next rising edge. If the two captured values differ, the path took longer than half a period for that transition, and the block records an error.

One launch output feeds several capture channels, so two nominally matched paths can be compared directly. Each channel counts its errors separately for rising and for falling launches. A host sets a window of N transitions. After the last of them has been judged, every count freezes and a one-cycle done pulse is raised. For each channel the block reports which polarity is slower. It also reports whether that polarity failed in at least half of its transitions. The clock period at which this flag changes is the point where the error rate crosses 50%, which marks the path delay even when the clock has jitter.

Top module: `pdly_err_mon`

## Requirements
- R1: While `enable_i` is high and fewer than N transitions have been launched, `launch_o` inverts at every rising clock edge. The first transition after reset or clear is rising (0 to 1). `launch_o` holds its level while `enable_i` is low.
- R2: The returned signal is sampled on the falling edge after the launch edge and again on the next rising edge. A transition counts as an error exactly when these two samples differ. A path delay below half a period gives no error, and a delay between half a period and one period gives an error.
- R3: An error is charged to the rising count when the judged launch went from 0 to 1, and to the falling count when it went from 1 to 0.
- R4: Each channel keeps its own counts and status, computed only from its own return input.
- R5: The window length N is read from `win_len_i`. After N transitions have been judged, `done_o` is high for exactly one cycle. The window holds ceil(N/2) rising and floor(N/2) falling transitions.
- R6: After done, the counts, the status outputs and `launch_o` keep their values until clear.
- R7: `slow_fall_o` of a channel is 1 exactly when its falling count is greater than its rising count. On a tie the rising polarity is treated as the slower one.
- R8: Each error count saturates at 2^CNT_W-1 and never wraps.
- R9: `at_half_o` of a channel is 1 only after done. It is then 1 exactly when twice the slower polarity's count is at least the number of transitions of that polarity in the window.
- R10: A cycle with `clear_i` high sets all counts to zero, ends the done state, resets the transition tallies and returns `launch_o` to 0 on the next edge.
- R11: A capture mismatch that does not belong to a transition launched by the block is never counted. This covers any mismatch seen before enable, and the captures of the first two cycles after enable that carry no launched transition.
- R12: After reset, `launch_o`, `done_o`, all counts and `at_half_o` are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; launch and shadow capture use the rising edge, main capture uses the falling edge |
| rst_n | input | 1 | Asynchronous active-low reset, deasserted synchronously |
| clear_i | input | 1 | Synchronous clear of counts, tallies and launch level |
| enable_i | input | 1 | Allows launching of transitions |
| win_len_i | input | WIN_W | Window length N in transitions, held stable during a run |
| launch_o | output | 1 | Toggling launch level into the path under test |
| ret_i | input | NCH | Returned signal of each channel's path |
| done_o | output | 1 | One-cycle pulse when the window is complete |
| rise_err_o | output | NCH*CNT_W | Rising-launch error count per channel, channel 0 in the low bits |
| fall_err_o | output | NCH*CNT_W | Falling-launch error count per channel, channel 0 in the low bits |
| slow_fall_o | output | NCH | Per channel, 1 when the falling polarity is slower |
| at_half_o | output | NCH | Per channel, slower polarity has an error rate of at least 50% |

## Verification
The bench builds the monitor with two channels, a 6-bit window length and 4-bit error counts. This keeps every window from 1 to 63 transitions short. A 40-transition window with every rising launch failing then drives a count past its 15 ceiling. The bench models each path with a per-polarity delay of either 1 ns or 6 ns against the 8 ns period, or with the long delay applied to every other transition of one polarity. It sweeps all pairings of these models on both channels over a set of odd and even window lengths, which covers ties, exact 50% rates, empty falling halves and saturation. Separate runs inject a capture mismatch before enable and pause the launch in the middle of a window.

// File: rtl/pdm_pkg.sv
package pdm_pkg;

  // Direction of a launched transition, as seen on the new launch level.
  typedef enum logic {
    POL_FALL = 1'b0,
    POL_RISE = 1'b1
  } pol_e;

  function automatic int unsigned max_of(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/pdm_launch.sv
module pdm_launch #(
  parameter int unsigned WIN_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear_i,
  input  logic             enable_i,
  input  logic             frozen_i,
  input  logic [WIN_W-1:0] win_len_i,
  output logic             launch_o,
  output logic             fired_o
);

  logic             lvl_q, lvl_d;
  logic             fired_q, fired_d;
  logic [WIN_W-1:0] sent_q, sent_d;
  logic             go;

  always_comb begin
    go      = enable_i && !frozen_i && (sent_q < win_len_i);
    lvl_d   = lvl_q;
    sent_d  = sent_q;
    fired_d = 1'b0;
    if (clear_i) begin
      lvl_d  = 1'b0;
      sent_d = '0;
    end else if (go) begin
      lvl_d   = ~lvl_q;
      sent_d  = sent_q + 1'b1;
      fired_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lvl_q   <= 1'b0;
      sent_q  <= '0;
      fired_q <= 1'b0;
    end else begin
      lvl_q   <= lvl_d;
      sent_q  <= sent_d;
      fired_q <= fired_d;
    end
  end

  assign launch_o = lvl_q;
  assign fired_o  = fired_q;

endmodule

// File: rtl/pdm_window.sv
module pdm_window
  import pdm_pkg::*;
#(
  parameter int unsigned WIN_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear_i,
  input  logic             fired_i,
  input  logic             launch_lvl_i,
  input  logic [WIN_W-1:0] win_len_i,
  output logic             eval_o,
  output pol_e             eval_pol_o,
  output logic             frozen_o,
  output logic             done_o,
  output logic [WIN_W-1:0] rise_tr_o,
  output logic [WIN_W-1:0] fall_tr_o
);

  // Stage aligned with the capture retiming: the transition fired at edge k
  // is judged in the cycle after edge k+1.
  logic             vld_q, vld_d;
  pol_e             pol_q, pol_d;
  logic [WIN_W-1:0] seen_q, seen_d;
  logic             frozen_q, frozen_d;
  logic             done_q, done_d;
  logic             last;

  always_comb begin
    eval_o   = vld_q && !frozen_q && !clear_i;
    last     = eval_o && (((WIN_W+1)'(seen_q) + 1'b1) == (WIN_W+1)'(win_len_i));
    vld_d    = fired_i && !clear_i;
    pol_d    = launch_lvl_i ? POL_RISE : POL_FALL;
    seen_d   = seen_q;
    frozen_d = frozen_q;
    done_d   = 1'b0;
    if (clear_i) begin
      seen_d   = '0;
      frozen_d = 1'b0;
    end else if (eval_o) begin
      seen_d   = seen_q + 1'b1;
      frozen_d = frozen_q || last;
      done_d   = last;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q    <= 1'b0;
      pol_q    <= POL_FALL;
      seen_q   <= '0;
      frozen_q <= 1'b0;
      done_q   <= 1'b0;
    end else begin
      vld_q    <= vld_d;
      pol_q    <= pol_d;
      seen_q   <= seen_d;
      frozen_q <= frozen_d;
      done_q   <= done_d;
    end
  end

  assign eval_pol_o = pol_q;
  assign frozen_o   = frozen_q;
  assign done_o     = done_q;
  // The first launch after clear is rising, so rising takes the odd extra one.
  assign rise_tr_o  = WIN_W'(((WIN_W+1)'(win_len_i) + 1'b1) >> 1);
  assign fall_tr_o  = win_len_i >> 1;

endmodule

// File: rtl/pdm_capture.sv
module pdm_capture
  import pdm_pkg::*;
#(
  parameter int unsigned CNT_W = 16,
  parameter int unsigned WIN_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear_i,
  input  logic             ret_i,
  input  logic             eval_i,
  input  pol_e             eval_pol_i,
  input  logic             frozen_i,
  input  logic [WIN_W-1:0] rise_tr_i,
  input  logic [WIN_W-1:0] fall_tr_i,
  output logic [CNT_W-1:0] rise_err_o,
  output logic [CNT_W-1:0] fall_err_o,
  output logic             slow_fall_o,
  output logic             at_half_o
);

  localparam int unsigned CMP_W = max_of(CNT_W, WIN_W) + 2;

  logic main_q;
  logic main_r_q;
  logic shadow_q;
  logic mismatch;
  logic [1:0][CNT_W-1:0] cnt_all;

  // Half-period sample.
  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) main_q <= 1'b0;
    else        main_q <= ret_i;
  end

  // Full-period sample, and the half-period sample moved onto the rising edge.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      main_r_q <= 1'b0;
      shadow_q <= 1'b0;
    end else begin
      main_r_q <= main_q;
      shadow_q <= ret_i;
    end
  end

  assign mismatch = main_r_q ^ shadow_q;

  for (genvar p = 0; p < 2; p++) begin : g_pol
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic             hit;

    always_comb begin
      hit   = eval_i && mismatch && (eval_pol_i == ((p == 1) ? POL_RISE : POL_FALL));
      cnt_d = cnt_q;
      if (clear_i)                  cnt_d = '0;
      else if (hit && (cnt_q != '1)) cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cnt_q <= '0;
      else        cnt_q <= cnt_d;
    end

    assign cnt_all[p] = cnt_q;
  end

  logic [CNT_W-1:0] sel_err;
  logic [WIN_W-1:0] sel_tr;
  logic [CMP_W-1:0] err_x2;
  logic [CMP_W-1:0] tr_x;

  always_comb begin
    slow_fall_o = cnt_all[0] > cnt_all[1];
    sel_err     = slow_fall_o ? cnt_all[0] : cnt_all[1];
    sel_tr      = slow_fall_o ? fall_tr_i : rise_tr_i;
    err_x2      = CMP_W'(sel_err) << 1;
    tr_x        = CMP_W'(sel_tr);
    at_half_o   = frozen_i && (err_x2 >= tr_x);
  end

  assign rise_err_o = cnt_all[1];
  assign fall_err_o = cnt_all[0];

endmodule

// File: rtl/pdly_err_mon.sv
module pdly_err_mon
  import pdm_pkg::*;
#(
  parameter int unsigned NCH   = 2,
  parameter int unsigned WIN_W = 16,
  parameter int unsigned CNT_W = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 clear_i,
  input  logic                 enable_i,
  input  logic [WIN_W-1:0]     win_len_i,
  output logic                 launch_o,
  input  logic [NCH-1:0]       ret_i,
  output logic                 done_o,
  output logic [NCH*CNT_W-1:0] rise_err_o,
  output logic [NCH*CNT_W-1:0] fall_err_o,
  output logic [NCH-1:0]       slow_fall_o,
  output logic [NCH-1:0]       at_half_o
);

  logic             fired;
  logic             eval;
  pol_e             eval_pol;
  logic             frozen;
  logic [WIN_W-1:0] rise_tr;
  logic [WIN_W-1:0] fall_tr;

  pdm_launch #(.WIN_W(WIN_W)) launch_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .clear_i   (clear_i),
    .enable_i  (enable_i),
    .frozen_i  (frozen),
    .win_len_i (win_len_i),
    .launch_o  (launch_o),
    .fired_o   (fired)
  );

  pdm_window #(.WIN_W(WIN_W)) window_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .clear_i      (clear_i),
    .fired_i      (fired),
    .launch_lvl_i (launch_o),
    .win_len_i    (win_len_i),
    .eval_o       (eval),
    .eval_pol_o   (eval_pol),
    .frozen_o     (frozen),
    .done_o       (done_o),
    .rise_tr_o    (rise_tr),
    .fall_tr_o    (fall_tr)
  );

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    pdm_capture #(.CNT_W(CNT_W), .WIN_W(WIN_W)) capture_i (
      .clk         (clk),
      .rst_n       (rst_n),
      .clear_i     (clear_i),
      .ret_i       (ret_i[c]),
      .eval_i      (eval),
      .eval_pol_i  (eval_pol),
      .frozen_i    (frozen),
      .rise_tr_i   (rise_tr),
      .fall_tr_i   (fall_tr),
      .rise_err_o  (rise_err_o[c*CNT_W +: CNT_W]),
      .fall_err_o  (fall_err_o[c*CNT_W +: CNT_W]),
      .slow_fall_o (slow_fall_o[c]),
      .at_half_o   (at_half_o[c])
    );
  end

endmodule

// File: rtl/pdly_err_mon_chk.sv
module pdly_err_mon_chk #(
  parameter int unsigned NCH   = 2,
  parameter int unsigned CNT_W = 16
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 clear_i,
  input logic                 enable_i,
  input logic                 launch_o,
  input logic                 done_o,
  input logic                 frozen,
  input logic [NCH*CNT_W-1:0] rise_err_o,
  input logic [NCH*CNT_W-1:0] fall_err_o,
  input logic [NCH-1:0]       at_half_o
);

  // R5: done lasts a single cycle
  assert_done_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  // R5: the frozen state is entered only together with the done pulse
  assert_freeze_with_done_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(frozen) |-> done_o);

  // R1: no launch transition without enable
  assert_hold_when_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (!enable_i && !clear_i) |=> $stable(launch_o));

  // R6: results and launch level are held after done
  assert_frozen_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (frozen && !clear_i) |=> ($stable(rise_err_o) && $stable(fall_err_o) && $stable(launch_o)));

  // R9: status only in the done state
  assert_status_after_done_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (at_half_o != '0) |-> frozen);

  // R10: clear empties the counts
  assert_clear_counts_R10: assert property (@(posedge clk) disable iff (!rst_n)
    clear_i |=> ((rise_err_o == '0) && (fall_err_o == '0) && !done_o));

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    // R8: counts never step backwards, so they cannot wrap
    assert_no_wrap_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !clear_i |=> ((rise_err_o[c*CNT_W +: CNT_W] >= $past(rise_err_o[c*CNT_W +: CNT_W])) &&
                    (fall_err_o[c*CNT_W +: CNT_W] >= $past(fall_err_o[c*CNT_W +: CNT_W]))));
  end

endmodule

bind pdly_err_mon pdly_err_mon_chk #(.NCH(NCH), .CNT_W(CNT_W)) chk_i (
  .clk        (clk),
  .rst_n      (rst_n),
  .clear_i    (clear_i),
  .enable_i   (enable_i),
  .launch_o   (launch_o),
  .done_o     (done_o),
  .frozen     (frozen),
  .rise_err_o (rise_err_o),
  .fall_err_o (fall_err_o),
  .at_half_o  (at_half_o)
);

// File: tb/pdly_err_mon_tb_top.sv
`timescale 1ns/1ps
module pdly_err_mon_tb_top;

  localparam int NCH = 2;
  localparam int WW  = 6;
  localparam int CW  = 4;
  localparam int SAT = (1 << CW) - 1;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              clear_i = 1'b0;
  logic              enable_i = 1'b0;
  logic [WW-1:0]     win_len_i = '0;
  logic              launch_o;
  logic [NCH-1:0]    ret = '0;
  logic              done_o;
  logic [NCH*CW-1:0] rise_err_o;
  logic [NCH*CW-1:0] fall_err_o;
  logic [NCH-1:0]    slow_fall_o;
  logic [NCH-1:0]    at_half_o;

  int checks = 0;
  int fails  = 0;

  always #4 clk = ~clk;

  pdly_err_mon #(.NCH(NCH), .WIN_W(WW), .CNT_W(CW)) dut_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .clear_i     (clear_i),
    .enable_i    (enable_i),
    .win_len_i   (win_len_i),
    .launch_o    (launch_o),
    .ret_i       (ret),
    .done_o      (done_o),
    .rise_err_o  (rise_err_o),
    .fall_err_o  (fall_err_o),
    .slow_fall_o (slow_fall_o),
    .at_half_o   (at_half_o)
  );

  // Path model: mode 0 = 1 ns delay, 1 = 6 ns delay, 2 = 6 ns on odd-numbered
  // transitions of that polarity and 1 ns on the others. Period is 8 ns.
  int   mode_r [NCH];
  int   mode_f [NCH];
  logic glitch_req = 1'b0;
  logic prev_l = 1'b0;
  int   occ_r = 0;
  int   occ_f = 0;

  function automatic bit is_long(int mode, int occ);
    return (mode == 1) || ((mode == 2) && (occ % 2 == 1));
  endfunction

  always @(posedge clk) begin
    bit [NCH-1:0] lng;
    #1;
    if (clear_i) begin
      occ_r  = 0;
      occ_f  = 0;
      prev_l = launch_o;
      for (int c = 0; c < NCH; c++) ret[c] = launch_o;
    end else if (launch_o !== prev_l) begin
      prev_l = launch_o;
      if (launch_o) occ_r++; else occ_f++;
      for (int c = 0; c < NCH; c++) begin
        lng[c] = launch_o ? is_long(mode_r[c], occ_r) : is_long(mode_f[c], occ_f);
        if (!lng[c]) ret[c] = launch_o;
      end
      #5;
      for (int c = 0; c < NCH; c++) if (lng[c]) ret[c] = launch_o;
    end else if (glitch_req) begin
      #5;
      ret = ~ret;
    end
  end

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  function automatic int exp_err(int mode, int tr);
    int e;
    e = (mode == 0) ? 0 : (mode == 1) ? tr : (tr + 1) / 2;
    return (e > SAT) ? SAT : e;
  endfunction

  task automatic run_win(int n, int r0, int f0, int r1, int f1, bit glitch, int pause_at);
    int  rtr, ftr, got, hold;
    int  er [NCH];
    int  ef [NCH];
    int  mr [NCH];
    int  mf [NCH];
    logic [NCH*CW-1:0] hr, hf;
    logic hl;
    mr[0] = r0; mf[0] = f0; mr[1] = r1; mf[1] = f1;
    for (int c = 0; c < NCH; c++) begin mode_r[c] = 0; mode_f[c] = 0; end
    enable_i  = 1'b0;
    win_len_i = WW'(n);
    @(negedge clk) clear_i = 1'b1;
    @(negedge clk) clear_i = 1'b0;
    chk("R10 counts after clear", int'(rise_err_o | fall_err_o), 0);
    chk("R10 launch after clear", int'(launch_o), 0);
    chk("R10 done after clear", int'(done_o), 0);
    chk("R9 status before done", int'(at_half_o), 0);
    if (glitch) begin
      glitch_req = 1'b1;
      @(negedge clk) glitch_req = 1'b0;
      @(negedge clk);
    end
    for (int c = 0; c < NCH; c++) begin mode_r[c] = mr[c]; mode_f[c] = mf[c]; end
    enable_i = 1'b1;
    got = 0;
    for (int k = 0; k < 300 && got == 0; k++) begin
      @(negedge clk);
      if (k == 0) chk("R1 first launch rising", int'(launch_o), 1);
      if (k == 1 && n >= 2) chk("R1 second launch falling", int'(launch_o), 0);
      if (k == 0) chk("R9 status while running", int'(at_half_o), 0);
      if (pause_at > 0 && k == pause_at) begin
        enable_i = 1'b0;
        hold = int'(launch_o);
        for (int w = 0; w < 3; w++) begin
          @(negedge clk);
          chk("R1 launch held while disabled", int'(launch_o), hold);
        end
        enable_i = 1'b1;
      end
      if (done_o) got = 1;
    end
    chk("R5 done reached", got, 1);
    rtr = (n + 1) / 2;
    ftr = n / 2;
    for (int c = 0; c < NCH; c++) begin
      er[c] = exp_err(mr[c], rtr);
      ef[c] = exp_err(mf[c], ftr);
      chk($sformatf("R3 R8 rise count ch%0d n%0d", c, n), int'(rise_err_o[c*CW +: CW]), er[c]);
      chk($sformatf("R2 R4 fall count ch%0d n%0d", c, n), int'(fall_err_o[c*CW +: CW]), ef[c]);
      chk($sformatf("R7 slower polarity ch%0d", c), int'(slow_fall_o[c]), (ef[c] > er[c]) ? 1 : 0);
      if (ef[c] > er[c])
        chk($sformatf("R9 status ch%0d n%0d", c, n), int'(at_half_o[c]), (2 * ef[c] >= ftr) ? 1 : 0);
      else
        chk($sformatf("R9 status ch%0d n%0d", c, n), int'(at_half_o[c]), (2 * er[c] >= rtr) ? 1 : 0);
    end
    hr = rise_err_o; hf = fall_err_o; hl = launch_o;
    @(negedge clk);
    chk("R5 done is one cycle", int'(done_o), 0);
    repeat (4) @(negedge clk);
    chk("R6 rise counts held", int'(rise_err_o == hr), 1);
    chk("R6 fall counts held", int'(fall_err_o == hf), 1);
    chk("R6 launch held", int'(launch_o), int'(hl));
    enable_i = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    int lens [8] = '{1, 2, 3, 7, 8, 31, 40, 63};
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R12 launch after reset", int'(launch_o), 0);
    chk("R12 done after reset", int'(done_o), 0);
    chk("R12 counts after reset", int'(rise_err_o | fall_err_o), 0);
    chk("R12 status after reset", int'(at_half_o), 0);

    // R11: a stray capture mismatch before enable must not be counted
    run_win(4, 0, 0, 0, 0, 1'b1, 0);
    // R1: a pause in the middle of a window keeps the tallies consistent
    run_win(20, 2, 1, 1, 0, 1'b0, 4);

    for (int i = 0; i < 8; i++)
      for (int rm = 0; rm < 3; rm++)
        for (int fm = 0; fm < 3; fm++)
          run_win(lens[i], rm, fm, fm, rm, 1'b0, 0);

    summary();
  end

endmodule